// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core from four sources: an external pin, a timer overflow, a time-base tick and a real-time-clock tick. Each source line is edge-detected into a sticky request flag. A flag only leads to service when three things are true: its own enable is set, the global enable is set, and the core reports that the return stack still has a free slot.

The core pulses `sample_i` once per instruction cycle. On that edge, the block takes the highest-priority pending source. It clears that source's flag and the global enable. In the next cycle it raises a one-cycle call request that carries the fixed vector address. Software reads and writes the enables and flags through two byte-wide registers. A return-from-interrupt strobe sets the global enable again. A plain return strobe leaves the global enable as it is.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, both registers read 0x00 and `call_o` is 0.
- R2: Register 0 (`reg_sel_i`=0) holds: bit0 global enable, bits 1/2/3 the enables of external/timer/time-base, and bits 4/5/6 the flags of external/timer/time-base. Bit 7 always reads 0.
- R3: Register 1 (`reg_sel_i`=1) holds the real-time-clock enable in bit0 and its flag in bit4. Every other bit reads 0.
- R4: Source index 0 (external) has the highest priority, then 1 (timer), then 2 (time base), then 3 (real-time clock, lowest). The vector addresses are 0x04, 0x08, 0x0C and 0x10.
- R5: A source is accepted only at a clock edge where all of these hold: `sample_i` is 1, `stack_full_i` is 0, the global enable is 1, the source's enable is 1 and its flag is 1.
- R6: At the edge where a source is accepted, its flag and the global enable clear. In the next cycle `call_o` is 1 and `vector_o` holds that source's vector.
- R7: `call_o` is high for exactly one cycle. No source is accepted at the edge that ends the pulse.
- R8: A `reti_i` strobe sets the global enable. A `ret_i` strobe on its own leaves the global enable unchanged.
- R9: A flag stays set while it is masked or blocked. It clears only when its source is serviced or when software writes 0 to it.
- R10: A source input held high sets its flag once only. The flag is set again only after the input goes low and then high again.
- R11: A software write of 1 sets a flag. A rising source edge in the same cycle as a software write of 0 leaves the flag set.
- R12: A flag set at any edge before a sampling edge is serviced at that sampling edge. With no sampling edge, no call is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Sampling-phase strobe from the core |
| src_i | input | 4 | Request lines: external, timer, time base, real-time clock |
| stack_full_i | input | 1 | Return stack has no free slot |
| ret_i | input | 1 | Plain return strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select (0 or 1) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| call_o | output | 1 | One-cycle call request |
| vector_o | output | 5 | Vector address of the call |

## Verification
The bench builds the block with its default four sources and a vector step of 4. This keeps the state space small enough to sweep every one of the 256 combinations of per-source enables and flags through a sampling edge. Each combination checks the winner, the vector and the cleared state against an arithmetic priority pick. Directed sequences then cover stack-full blocking, the return strobes, input held high, and software writes that collide with hardware edges.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_N    = 4;
  localparam int IDX_W    = $clog2(IRQ_N);
  localparam int VEC_W    = 5;
  localparam int VEC_STEP = 4;
  localparam int REG_W    = 8;

  function automatic logic [VEC_W-1:0] vec_addr(input logic [IDX_W-1:0] idx);
    return VEC_W'((int'(idx) + 1) * VEC_STEP);
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[i] <= 1'b0;
      else         lvl_q[i] <= lvl_i[i];
    end
    assign rise_o[i] = lvl_i[i] & ~lvl_q[i];
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // lowest index wins
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [IRQ_N-1:0] set_i,
  input  logic [IRQ_N-1:0] clr_i,
  input  logic             accept_i,
  input  logic             reti_i,
  output logic [IRQ_N-1:0] en_o,
  output logic [IRQ_N-1:0] flag_o,
  output logic             glob_en_o,
  output logic [REG_W-1:0] rdata_o
);
  logic [IRQ_N-1:0] en_q, flag_q, en_n, flag_n, sw_we, sw_en, sw_flag;
  logic             ge_q, ge_n;
  logic             wr0, wr1;
  logic             unused_wbit;

  assign wr0 = wr_i & ~sel_i;
  assign wr1 = wr_i & sel_i;
  assign unused_wbit = wdata_i[7];

  // per-source software write fields
  always_comb begin
    for (int i = 0; i < IRQ_N - 1; i++) begin
      sw_we[i]   = wr0;
      sw_en[i]   = wdata_i[1 + i];
      sw_flag[i] = wdata_i[4 + i];
    end
    sw_we[IRQ_N-1]   = wr1;
    sw_en[IRQ_N-1]   = wdata_i[0];
    sw_flag[IRQ_N-1] = wdata_i[4];
  end

  // hardware set dominates both software clear and service clear
  always_comb begin
    for (int i = 0; i < IRQ_N; i++) begin
      en_n[i]   = sw_we[i] ? sw_en[i] : en_q[i];
      flag_n[i] = ((sw_we[i] ? sw_flag[i] : flag_q[i]) & ~clr_i[i]) | set_i[i];
    end
    ge_n = wr0 ? wdata_i[0] : ge_q;
    if (reti_i)   ge_n = 1'b1;
    if (accept_i) ge_n = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      flag_q <= '0;
      ge_q   <= 1'b0;
    end else begin
      en_q   <= en_n;
      flag_q <= flag_n;
      ge_q   <= ge_n;
    end
  end

  assign en_o      = en_q;
  assign flag_o    = flag_q;
  assign glob_en_o = ge_q;

  always_comb begin
    if (!sel_i) rdata_o = {1'b0, flag_q[2:0], en_q[2:0], ge_q};
    else        rdata_o = {3'b000, flag_q[3], 3'b000, en_q[3]};
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic [IRQ_N-1:0] src_i,
  input  logic             stack_full_i,
  input  logic             ret_i,
  input  logic             reti_i,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             call_o,
  output logic [VEC_W-1:0] vector_o
);
  logic [IRQ_N-1:0] rise, en, flag, pend, gnt, clr;
  logic [IDX_W-1:0] win_idx;
  logic             any, glob_en, accept, call_q;
  logic [VEC_W-1:0] vec_q;
  logic             unused_ret;

  // plain return does not touch the global enable
  assign unused_ret = ret_i;

  irq_edge_det #(.W(IRQ_N)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (src_i),
    .rise_o (rise)
  );

  assign pend = flag & en & {IRQ_N{glob_en}};

  irq_prio_arb #(.N(IRQ_N), .IW(IDX_W)) u_arb (
    .req_i (pend),
    .gnt_o (gnt),
    .idx_o (win_idx),
    .any_o (any)
  );

  assign accept = sample_i & ~stack_full_i & ~call_q & any;
  assign clr    = accept ? gnt : '0;

  irq_ctrl_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .set_i     (rise),
    .clr_i     (clr),
    .accept_i  (accept),
    .reti_i    (reti_i),
    .en_o      (en),
    .flag_o    (flag),
    .glob_en_o (glob_en),
    .rdata_o   (reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      call_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      call_q <= accept;
      if (accept) vec_q <= vec_addr(win_idx);
    end
  end

  assign call_o   = call_q;
  assign vector_o = vec_q;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sample_i,
  input logic       stack_full_i,
  input logic       ret_i,
  input logic       reti_i,
  input logic       reg_wr_i,
  input logic       reg_sel_i,
  input logic       call_o,
  input logic [4:0] vector_o,
  input logic       glob_en
);
  // R7
  call_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |=> !call_o);

  // R4
  vec_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |-> (vector_o == 5'h04 || vector_o == 5'h08 ||
                vector_o == 5'h0C || vector_o == 5'h10));

  // R5
  accept_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(call_o) |-> ($past(sample_i) && !$past(stack_full_i)));

  // R6
  entry_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |-> !glob_en);

  // R8
  reti_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i |=> (glob_en || call_o));

  // R8
  ret_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !reti_i && !(reg_wr_i && !reg_sel_i)) |=> (call_o || glob_en == $past(glob_en)));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sample_i     (sample_i),
  .stack_full_i (stack_full_i),
  .ret_i        (ret_i),
  .reti_i       (reti_i),
  .reg_wr_i     (reg_wr_i),
  .reg_sel_i    (reg_sel_i),
  .call_o       (call_o),
  .vector_o     (vector_o),
  .glob_en      (glob_en)
);

// File: tb/irq_vec_ctrl_test.sv
`timescale 1ns/100ps
module irq_vec_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sample_i = 1'b0;
  logic [3:0] src_i = '0;
  logic       stack_full_i = 1'b0;
  logic       ret_i = 1'b0;
  logic       reti_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic       reg_sel_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       call_o;
  logic [4:0] vector_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  irq_vec_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .src_i(src_i),
    .stack_full_i(stack_full_i), .ret_i(ret_i), .reti_i(reti_i),
    .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .call_o(call_o), .vector_o(vector_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_sel_i = sel; reg_wdata_i = d; reg_wr_i = 1'b1;
    tick();
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    reg_sel_i = sel;
    #0.2;
    d = reg_rdata_o;
  endtask

  task automatic samp();
    sample_i = 1'b1;
    tick();
    sample_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    tick();
    // R1 reset state
    rd(0, d); chk("R1 reg0", d, 8'h00);
    rd(1, d); chk("R1 reg1", d, 8'h00);
    chk("R1 call", call_o, 0);

    // R2 R3 unused bits read 0
    wr(0, 8'hFF); rd(0, d); chk("R2 reg0 mask", d, 8'h7F);
    wr(1, 8'hFF); rd(1, d); chk("R3 reg1 mask", d, 8'h11);
    wr(0, 8'h00); wr(1, 8'h00);

    // R4 R5 R6 R7 R12 sweep over flags x enables
    for (int f = 0; f < 16; f++) begin
      for (int e = 0; e < 16; e++) begin
        logic [3:0] fv, ev, pend, fn;
        int k;
        fv = f[3:0]; ev = e[3:0];
        pend = fv & ev;
        k = -1;
        for (int i = 3; i >= 0; i--) if (pend[i]) k = i;
        fn = fv;
        if (k >= 0) fn[k] = 1'b0;
        wr(1, {3'b000, fv[3], 3'b000, ev[3]});
        wr(0, {1'b0, fv[2:0], ev[2:0], 1'b1});
        tick();
        chk("R12 no call before sample", call_o, 0);
        samp();
        chk("R5 call", call_o, (k >= 0));
        if (k >= 0) chk("R4 vector", vector_o, (k + 1) * 4);
        rd(0, d); chk("R6 reg0 after", d, {1'b0, fn[2:0], ev[2:0], (k < 0)});
        rd(1, d); chk("R6 reg1 after", d, {3'b000, fn[3], 3'b000, ev[3]});
        tick();
        chk("R7 pulse end", call_o, 0);
      end
    end

    // R5 R9 stack full blocks, flag kept
    wr(1, 8'h00);
    wr(0, 8'h13);
    stack_full_i = 1'b1;
    samp();
    chk("R5 stack full call", call_o, 0);
    rd(0, d); chk("R9 flag kept stack full", d, 8'h13);
    stack_full_i = 1'b0;
    samp();
    chk("R5 call after room", call_o, 1);
    chk("R4 ext vector", vector_o, 5'h04);
    rd(0, d); chk("R6 cleared", d, 8'h02);

    // R8 ret keeps, reti sets
    ret_i = 1'b1; tick(); ret_i = 1'b0;
    rd(0, d); chk("R8 ret keeps ge", d[0], 0);
    reti_i = 1'b1; tick(); reti_i = 1'b0;
    rd(0, d); chk("R8 reti sets ge", d[0], 1);

    // R9 R12 masked flag persists, serviced later
    wr(0, 8'h20);
    samp();
    chk("R9 masked no call", call_o, 0);
    rd(0, d); chk("R9 masked flag kept", d, 8'h20);
    wr(0, 8'h25);
    repeat (4) tick();
    chk("R12 idle no call", call_o, 0);
    samp();
    chk("R12 call at sample", call_o, 1);
    chk("R4 timer vector", vector_o, 5'h08);

    // R7 sample held two cycles with two pending
    wr(0, 8'h37);
    sample_i = 1'b1;
    tick();
    chk("R7 first call", call_o, 1);
    chk("R4 prio ext", vector_o, 5'h04);
    tick();
    sample_i = 1'b0;
    chk("R7 second cycle", call_o, 0);
    rd(0, d); chk("R7 timer flag kept", d, 8'h26);

    // R10 held input sets once
    wr(0, 8'h00);
    src_i = 4'b0100;
    tick();
    rd(0, d); chk("R10 set on edge", d, 8'h40);
    repeat (3) tick();
    wr(0, 8'h00);
    tick();
    rd(0, d); chk("R10 held no reset", d, 8'h00);
    src_i = 4'b0000;
    tick();

    // R11 hw edge beats sw zero; sw one sets
    src_i = 4'b0100;
    wr(0, 8'h00);
    rd(0, d); chk("R11 hw beats sw0", d, 8'h40);
    src_i = 4'b0000;
    wr(1, 8'h10);
    rd(1, d); chk("R11 sw1 sets", d, 8'h10);
    rd(0, d); chk("R11 reg0 unchanged", d, 8'h40);

    tick();
    finish_run();
  end
endmodule